// File: doc/BRIEF.md
# Selectable Digital Soft-Start Ramp

This block produces the digital reference code for an error amplifier while a switching converter starts up. After a start event it counts oscillator cycles, one code step per cycle, so that an external converter turns the code into a slow rising reference. The ramp is slow enough that the output capacitor charges without a current surge. A two-bit strap input picks one of three ramp speeds, given as the number of oscillator cycles needed to sweep the full 1 V scale.

The ramp does not run to full scale. As soon as it would pass the fixed internal reference, which is 0.591 V written as a 12-bit code, the output locks to that fixed code for good. At the same moment the soft-start busy flag drops, and power-good logic uses that flag to know when it may assert.

A new ramp begins on any of these events: the enable input rising while the supply is good, the undervoltage condition clearing while the block is enabled, or a restart request. A restart request comes from hiccup-fault recovery or from recovery after thermal shutdown.

Top module: `soft_start_ramp`

## Requirements
- R1: During and after reset, until the first start, `ref_code` is 0 and `ss_busy` is 1.
- R2: After a start, every clock cycle with `osc_tick` high raises `ref_code` by one step. The step is 2 codes for `ss_sel`=00, 4 codes for `ss_sel`=01 and 8 codes for `ss_sel`=10. These steps give a full 4096-code sweep in 2048, 1024 and 512 ticks.
- R3: The value `ss_sel`=11 gives the same 4-code step as 01.
- R4: `ref_code` never goes above the fixed code 2420. The tick that would take the ramp above 2420 sets `ref_code` to 2420 and clears `ss_busy` on the same edge. This happens after 1211, 606 and 303 ticks for steps 2, 4 and 8.
- R5: After that handover, further ticks leave `ref_code` at 2420 and `ss_busy` at 0.
- R6: Cycles with `osc_tick` low leave `ref_code` and `ss_busy` unchanged.
- R7: A start happens on the first clock where `en` and `uv_ok` are both high after either was low. While either input is low, `ref_code` is 0 and `ss_busy` is 1, and ticks have no effect.
- R8: A `restart_req` pulse while running sets `ref_code` to 0 and `ss_busy` to 1, whether the ramp is mid-way or already handed over. The ramp then starts again from 0.
- R9: `ss_sel` is sampled only at a start. A change during a ramp does not alter the step size.
- R10: A start takes priority over a tick in the same cycle, so the ramp shows 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Enable command |
| uv_ok | input | 1 | High when both undervoltage monitors are satisfied |
| restart_req | input | 1 | One-cycle pulse from fault or thermal recovery |
| osc_tick | input | 1 | One-cycle pulse per oscillator period |
| ss_sel | input | 2 | Ramp length strap: 00 low, 01 floating, 10 high, 11 treated as floating |
| ref_code | output | 12 | Effective reference code for the error amplifier |
| ss_busy | output | 1 | High until the ramp hands over to the fixed reference |

## Verification
Each of the four select codes is run with tick counts that end just before and just after the crossover. This separates a correct step size from one that is off by a factor, and a correct handover from one that is a tick early or late. Long runs of ticks past the crossover show that the output stays held. Tick trains with idle gaps show that only oscillator cycles advance the ramp, and not clock cycles. Directed sequences cover four more cases: a restart mid-ramp and after handover, a restart that lands on the same edge as a tick, a strap change during a ramp, and enable or undervoltage dropping out.

// File: rtl/ss_ramp_pkg.sv
package ss_ramp_pkg;

  typedef enum logic [1:0] {
    SEL_LOW   = 2'b00,
    SEL_FLOAT = 2'b01,
    SEL_HIGH  = 2'b10,
    SEL_ALT   = 2'b11
  } ss_sel_e;

  // Rounded code for a millivolt level on a full scale of (2^code_w - 1).
  function automatic int fixed_code(int code_w, int ref_mv, int fs_mv);
    return (ref_mv * ((1 << code_w) - 1) + fs_mv / 2) / fs_mv;
  endfunction

  // Strap value 11 has no own speed; fold it onto the floating setting.
  function automatic ss_sel_e norm_sel(logic [1:0] raw);
    return (raw == 2'b11) ? SEL_FLOAT : ss_sel_e'(raw);
  endfunction

  function automatic int max3(int a, int b, int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/ss_trigger.sv
module ss_trigger (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic uv_ok,
  input  logic restart_req,
  output logic run,
  output logic start
);
  logic run_q;

  assign run   = en & uv_ok;
  assign start = run & (~run_q | restart_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run;
  end

  // R7: a start is only ever issued while both qualifiers are high
  p_start_needs_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (en && uv_ok));

endmodule

// File: rtl/ss_counter.sv
module ss_counter
  import ss_ramp_pkg::*;
#(
  parameter int CODE_W   = 12,
  parameter int CNT_W    = 12,
  parameter int SH_LOW   = 1,
  parameter int SH_FLOAT = 2,
  parameter int SH_HIGH  = 3,
  parameter int FIXED    = 2420
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              start,
  input  logic              osc_tick,
  input  logic [1:0]        ss_sel,
  output logic [CODE_W-1:0] ramp,
  output logic              done
);
  localparam int EXT_W = CODE_W + CNT_W;
  localparam logic [CODE_W-1:0] FULL  = '1;
  localparam logic [CODE_W-1:0] FIX_C = CODE_W'(FIXED);

  ss_sel_e          sel_q;
  logic [CNT_W-1:0] cnt;
  logic             advance;
  logic             cross_next;

  function automatic int shift_of(ss_sel_e s);
    case (s)
      SEL_LOW:  return SH_LOW;
      SEL_HIGH: return SH_HIGH;
      default:  return SH_FLOAT;
    endcase
  endfunction

  function automatic logic [CODE_W-1:0] ramp_of(logic [CNT_W-1:0] c, ss_sel_e s);
    logic [EXT_W-1:0] wide;
    wide = EXT_W'(c) << shift_of(s);
    return (wide > EXT_W'(FULL)) ? FULL : wide[CODE_W-1:0];
  endfunction

  assign ramp       = ramp_of(cnt, sel_q);
  assign advance    = run & ~start & osc_tick & ~done;
  assign cross_next = ramp_of(cnt + CNT_W'(1), sel_q) > FIX_C;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      done  <= 1'b0;
      sel_q <= SEL_FLOAT;
    end else if (!run) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (start) begin
      cnt   <= '0;
      done  <= 1'b0;
      sel_q <= norm_sel(ss_sel);
    end else if (advance) begin
      cnt  <= cnt + CNT_W'(1);
      done <= cross_next;
    end
  end

  // R2: each qualified tick moves the count by exactly one
  p_one_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !start && osc_tick && !done) |=> (cnt == $past(cnt) + CNT_W'(1)));
  // R6: without a tick the ramp state holds
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !start && !osc_tick) |=> ($stable(cnt) && $stable(done)));
  // R5: handover is sticky while running
  p_done_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && run && !start) |=> (done && $stable(cnt)));
  // R7: dropping out clears the ramp
  p_stop_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0 && !done));
  // R8, R10: a start always lands on zero
  p_start_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt == '0 && !done));
  // R9: the strap is frozen between starts
  p_sel_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !start) |=> $stable(sel_q));

endmodule

// File: rtl/ss_ref_select.sv
module ss_ref_select #(
  parameter int CODE_W = 12,
  parameter int FIXED  = 2420
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] ramp,
  input  logic              done,
  output logic [CODE_W-1:0] ref_code,
  output logic              ss_busy
);
  localparam logic [CODE_W-1:0] FIX_C = CODE_W'(FIXED);

  assign ref_code = done ? FIX_C : ramp;
  assign ss_busy  = ~done;

  // R4: the counter never presents a ramp past the crossover while still ramping
  p_ramp_below_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (ramp <= FIX_C));
  // R4: the ramp only rises toward the crossover, it never jumps over it
  p_handover_adjacent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(ramp) <= FIX_C));

endmodule

// File: rtl/soft_start_ramp.sv
module soft_start_ramp
  import ss_ramp_pkg::*;
#(
  parameter int CODE_W      = 12,
  parameter int REF_MV      = 591,
  parameter int FS_MV       = 1000,
  parameter int LOG_N_LOW   = 11,
  parameter int LOG_N_FLOAT = 10,
  parameter int LOG_N_HIGH  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              uv_ok,
  input  logic              restart_req,
  input  logic              osc_tick,
  input  logic [1:0]        ss_sel,
  output logic [CODE_W-1:0] ref_code,
  output logic              ss_busy
);
  localparam int FIXED = fixed_code(CODE_W, REF_MV, FS_MV);
  localparam int CNT_W = max3(LOG_N_LOW, LOG_N_FLOAT, LOG_N_HIGH) + 1;

  logic              run;
  logic              start;
  logic [CODE_W-1:0] ramp;
  logic              done;

  ss_trigger u_trig (
    .clk(clk), .rst_n(rst_n), .en(en), .uv_ok(uv_ok),
    .restart_req(restart_req), .run(run), .start(start)
  );

  ss_counter #(
    .CODE_W(CODE_W), .CNT_W(CNT_W),
    .SH_LOW(CODE_W - LOG_N_LOW), .SH_FLOAT(CODE_W - LOG_N_FLOAT),
    .SH_HIGH(CODE_W - LOG_N_HIGH), .FIXED(FIXED)
  ) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .start(start),
    .osc_tick(osc_tick), .ss_sel(ss_sel), .ramp(ramp), .done(done)
  );

  ss_ref_select #(.CODE_W(CODE_W), .FIXED(FIXED)) u_sel (
    .clk(clk), .rst_n(rst_n), .ramp(ramp), .done(done),
    .ref_code(ref_code), .ss_busy(ss_busy)
  );

  // R1: out of reset the block reports soft-start in progress at zero
  p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ref_code == '0 && ss_busy));
  // R4: busy only drops onto the fixed code
  p_fall_on_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ss_busy) |-> (ref_code == CODE_W'(FIXED)));

endmodule

// File: tb/tb_soft_start_ramp.sv
`timescale 1ns/1ps
module tb_soft_start_ramp;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, uv_ok = 1'b1, restart_req = 1'b0, osc_tick = 1'b0;
  logic [1:0]  ss_sel = 2'b00;
  logic [11:0] ref_code;
  logic        ss_busy;
  int          n_checks = 0, n_fail = 0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  soft_start_ramp dut (
    .clk(clk), .rst_n(rst_n), .en(en), .uv_ok(uv_ok), .restart_req(restart_req),
    .osc_tick(osc_tick), .ss_sel(ss_sel), .ref_code(ref_code), .ss_busy(ss_busy)
  );

  localparam int NV = 14;
  localparam logic [1:0] V_SEL [NV] = '{2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b01, 2'b01,
                                        2'b01, 2'b10, 2'b10, 2'b11, 2'b11, 2'b11, 2'b00};
  localparam int V_TICKS [NV] = '{0, 1, 100, 1210, 1211, 605, 606, 10, 302, 303, 605, 606, 3, 3000};
  localparam int V_REF   [NV] = '{0, 2, 200, 2420, 2420, 2420, 2420, 40, 2416, 2420, 2420, 2420, 12, 2420};
  localparam logic V_BUSY [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0,
                                   1'b1, 1'b0, 1'b1, 1'b0};

  task automatic check(string req, int exp_ref, logic exp_busy);
    n_checks++;
    if (ref_code !== 12'(exp_ref) || ss_busy !== exp_busy) begin
      n_fail++;
      $display("FAIL %s: ref_code=%0d ss_busy=%0b expected ref_code=%0d ss_busy=%0b",
               req, ref_code, ss_busy, exp_ref, exp_busy);
    end
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); osc_tick = 1'b1;
    end
    @(negedge clk); osc_tick = 1'b0;
  endtask

  task automatic sparse_ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); osc_tick = 1'b1;
      @(negedge clk); osc_tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic fresh_start(logic [1:0] sel);
    @(negedge clk); en = 1'b0;
    @(negedge clk); ss_sel = sel; en = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_restart(logic with_tick);
    @(negedge clk); restart_req = 1'b1; osc_tick = with_tick;
    @(negedge clk); restart_req = 1'b0; osc_tick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #1 check("R1 in reset", 0, 1'b1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", 0, 1'b1);

    // Table walk: R2 steps, R3 alias, R4 crossover, R5 hold past handover
    for (int v = 0; v < NV; v++) begin
      fresh_start(V_SEL[v]);
      if (V_TICKS[v] > 0) ticks(V_TICKS[v]);
      check($sformatf("R2/R3/R4/R5 vector %0d", v), V_REF[v], V_BUSY[v]);
    end

    // R7: undervoltage holds the ramp at zero
    @(negedge clk); en = 1'b0; uv_ok = 1'b0; ss_sel = 2'b00;
    @(negedge clk); en = 1'b1;
    ticks(50);
    check("R7 uv low ignores ticks", 0, 1'b1);
    @(negedge clk); uv_ok = 1'b1;
    @(negedge clk);
    ticks(5);
    check("R7 start on uv clear", 10, 1'b1);

    // R6: idle cycles between ticks do not advance
    sparse_ticks(5);
    check("R6 gapped ticks", 20, 1'b1);
    repeat (20) @(negedge clk);
    check("R6 no ticks hold", 20, 1'b1);

    // R8: restart mid-ramp
    pulse_restart(1'b0);
    check("R8 restart mid-ramp", 0, 1'b1);
    ticks(3);
    check("R8 ramp after restart", 6, 1'b1);

    // R7: enable drop mid-ramp
    @(negedge clk); en = 1'b0;
    @(negedge clk);
    check("R7 enable drop", 0, 1'b1);

    // R8: restart after handover
    fresh_start(2'b10);
    ticks(303);
    check("R4 handover step 8", 2420, 1'b0);
    pulse_restart(1'b0);
    check("R8 restart after handover", 0, 1'b1);

    // R9: strap change mid-ramp is ignored
    @(negedge clk); ss_sel = 2'b00;
    ticks(10);
    check("R9 strap change ignored", 80, 1'b1);

    // R10: restart and tick on the same edge, new strap sampled there
    pulse_restart(1'b1);
    check("R10 start beats tick", 0, 1'b1);
    ticks(1);
    check("R10 R9 step after resample", 2, 1'b1);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule